// File: doc/BRIEF.md
# E-Clock Multiplexed Bus Cycle Generator

This block is a bus master that turns simple requests into processor-style external bus cycles on a shared address/data byte lane. It divides the fast input clock by a fixed ratio to make the bus clock E. Every bus access takes exactly one E period. The first (low) half of the period carries the address. The second (high) half carries the data. There is no wait-state mechanism and no stretching of a cycle.

In each cycle the master does the following:
- drives the upper address byte for the whole period;
- pulses an address strobe early in the low half, so that an external transparent latch can hold the low address byte;
- in the high half, either drives write data or floats the lane and samples read data just before E falls.

A done pulse and the captured read byte return to the requester. Besides single read or write cycles, the master can replay two built-in four-cycle store patterns: extended-address and indexed. These give known bus traffic for testing.

Top module: `eclk_bus_master`

## Requirements
- R1: `bus_e` is low for DIV/2 input clocks and then high for DIV/2 input clocks, repeating, so E runs at 1/DIV of the input clock (DIV=4 by default).
- R2: In an active cycle, `bus_as` is high only during the first input clock of the low half of E. The low address byte is on `bus_ad_out` with `bus_ad_oe`=1 for the whole low half, so it is unchanged in the clock after the strobe falls.
- R3: `bus_addr_hi` and `bus_rw_n` stay constant over the whole E period. In a period with no cycle, `bus_rw_n`=1, `bus_addr_hi`=0, `bus_as`=0 and `bus_ad_oe`=0.
- R4: In a write cycle (`bus_rw_n`=0), `bus_ad_oe`=1 and `bus_ad_out` holds the write byte for the whole high half of E.
- R5: In a read cycle, `bus_ad_oe`=0 in the high half. `rsp_rdata` takes the value of `bus_ad_in` from the last input clock before E falls.
- R6: Every completed bus cycle, including each step of a replayed pattern, gives one `rsp_done` pulse of one input clock. The pulse comes in the second input clock after E falls, that is, one clock after the fall.
- R7: `req_ready` is high only in the last input clock of an E period, and only when no pattern is still in progress. A `req_start` at any other time is ignored and makes no bus cycle. An accepted request runs in the next E period, so cycles can follow back to back.
- R8: The kind encoding is: `req_kind`=2'b00 (or 2'b11) gives one cycle at `req_addr`, a write when `req_write`=1 with data `req_wdata`.
- R9: `req_kind`=2'b01 replays an extended store. The addresses are OP, OP+1, OP+2 and then `req_opnd`, with `bus_rw_n` at 1,1,1,0. OP is `req_addr`, and the last cycle writes `req_wdata`.
- R10: `req_kind`=2'b10 replays an indexed store. The addresses are OP, OP+1, 0xFFFF and then `req_index` plus the zero-extended low byte of `req_opnd` (mod 2^16), with `bus_rw_n` at 1,1,1,0. The last cycle writes `req_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast input clock |
| rst_n | input | 1 | asynchronous reset, active low |
| req_start | input | 1 | request strobe, taken only while req_ready is high |
| req_kind | input | 2 | 00/11 single, 01 extended store, 10 indexed store |
| req_write | input | 1 | single cycle: 1 write, 0 read |
| req_addr | input | 16 | single-cycle address, or the pattern's first address |
| req_wdata | input | 8 | write byte (stored accumulator for patterns) |
| req_opnd | input | 16 | target address (extended) or offset in bits 7:0 (indexed) |
| req_index | input | 16 | index base for the indexed pattern |
| req_ready | output | 1 | request acceptance window |
| bus_e | output | 1 | bus clock E |
| bus_as | output | 1 | address strobe |
| bus_rw_n | output | 1 | 1 read, 0 write |
| bus_addr_hi | output | 8 | upper address byte |
| bus_ad_out | output | 8 | shared lane: low address, then write data |
| bus_ad_oe | output | 1 | shared lane output enable |
| bus_ad_in | input | 8 | shared lane input for read data |
| rsp_done | output | 1 | cycle-complete pulse |
| rsp_rdata | output | 8 | captured read byte |

## Verification
In one input clock, the last clock of an E period, the master samples read data for the ending cycle, decides whether a pattern goes on, and may accept a new request. The bench provokes this in three ways: it issues back-to-back single reads and writes, it holds `req_start` high through a whole replayed pattern, and it issues a request in the same clock that a pattern's final write ends. A bus monitor then judges the results. It compares each strobed cycle with an arithmetic list of expected addresses, directions and data. It checks read bytes against a modelled memory function of the address. It finds any extra cycle or lost done pulse by count.

// File: rtl/eclk_bus_pkg.sv
package eclk_bus_pkg;
   typedef enum logic [1:0] {
      KIND_SINGLE  = 2'b00,
      KIND_EXT_ST  = 2'b01,
      KIND_IDX_ST  = 2'b10,
      KIND_RSVD    = 2'b11
   } req_kind_e;

   localparam int unsigned PATTERN_STEPS = 4;
endpackage

// File: rtl/eclk_phase_gen.sv
module eclk_phase_gen #(
   parameter int unsigned DIV = 4,
   localparam int unsigned PW = $clog2(DIV),
   localparam int unsigned HALF = DIV / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] ph,
   output logic          e_out,
   output logic          wrap
);
   logic [PW-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph_q <= '0;
      else if (ph_q == PW'(DIV - 1))
         ph_q <= '0;
      else
         ph_q <= ph_q + 1'b1;
   end

   assign ph    = ph_q;
   assign e_out = (ph_q >= PW'(HALF));
   assign wrap  = (ph_q == PW'(DIV - 1));

   p_e_rise_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(e_out) |-> (ph_q == PW'(HALF)));
   p_e_fall_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (!e_out && ph_q == '0));
endmodule

// File: rtl/eclk_seq_addr.sv
module eclk_seq_addr
   import eclk_bus_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8
) (
   input  req_kind_e     kind,
   input  logic [1:0]    step,
   input  logic          single_wr,
   input  logic [AW-1:0] op_addr,
   input  logic [AW-1:0] opnd,
   input  logic [AW-1:0] index,
   output logic [AW-1:0] cyc_addr,
   output logic          cyc_rw_n
);
   logic [AW-1:0] off_ext;

   assign off_ext = {{(AW-DW){1'b0}}, opnd[DW-1:0]};

   always_comb begin
      cyc_addr = op_addr;
      cyc_rw_n = 1'b1;
      unique case (kind)
         KIND_EXT_ST, KIND_IDX_ST: begin
            unique case (step)
               2'd0: cyc_addr = op_addr;
               2'd1: cyc_addr = op_addr + AW'(1);
               2'd2: cyc_addr = (kind == KIND_EXT_ST) ? op_addr + AW'(2) : '1;
               default: begin
                  cyc_addr = (kind == KIND_EXT_ST) ? opnd : index + off_ext;
                  cyc_rw_n = 1'b0;
               end
            endcase
         end
         default: begin
            cyc_addr = op_addr;
            cyc_rw_n = !single_wr;
         end
      endcase
   end
endmodule

// File: rtl/eclk_bus_master.sv
module eclk_bus_master
   import eclk_bus_pkg::*;
#(
   parameter int unsigned DIV = 4,
   parameter int unsigned AW  = 16,
   parameter int unsigned DW  = 8,
   localparam int unsigned PW = $clog2(DIV),
   localparam int unsigned HALF = DIV / 2,
   localparam int unsigned HW = AW - DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_start,
   input  logic [1:0]    req_kind,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [AW-1:0] req_opnd,
   input  logic [AW-1:0] req_index,
   output logic          req_ready,
   output logic          bus_e,
   output logic          bus_as,
   output logic          bus_rw_n,
   output logic [HW-1:0] bus_addr_hi,
   output logic [DW-1:0] bus_ad_out,
   output logic          bus_ad_oe,
   input  logic [DW-1:0] bus_ad_in,
   output logic          rsp_done,
   output logic [DW-1:0] rsp_rdata
);
   if (DIV < 4 || (DIV % 2) != 0) begin : g_bad_div
      $error("eclk_bus_master: DIV must be even and at least 4");
   end
   if (AW <= DW || DW < 1) begin : g_bad_width
      $error("eclk_bus_master: AW must exceed DW");
   end

   logic [PW-1:0] ph;
   logic          wrap;

   eclk_phase_gen #(.DIV(DIV)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .ph    (ph),
      .e_out (bus_e),
      .wrap  (wrap)
   );

   // Registered cycle descriptor
   logic          act_q;
   req_kind_e     kind_q;
   logic [1:0]    step_q;
   logic          wr_q;
   logic [AW-1:0] op_q, opnd_q, idx_q;
   logic [DW-1:0] wd_q;
   logic          fin_q, done_q;
   logic [DW-1:0] rdata_q;

   logic [AW-1:0] cyc_addr;
   logic          cyc_rw_n;

   eclk_seq_addr #(.AW(AW), .DW(DW)) u_addr (
      .kind      (kind_q),
      .step      (step_q),
      .single_wr (wr_q),
      .op_addr   (op_q),
      .opnd      (opnd_q),
      .index     (idx_q),
      .cyc_addr  (cyc_addr),
      .cyc_rw_n  (cyc_rw_n)
   );

   logic is_pattern, cont;
   assign is_pattern = (kind_q == KIND_EXT_ST) || (kind_q == KIND_IDX_ST);
   assign cont       = act_q && is_pattern && (step_q != 2'(PATTERN_STEPS - 1));
   assign req_ready  = wrap && !cont;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         kind_q <= KIND_SINGLE;
         step_q <= '0;
         wr_q   <= 1'b0;
         op_q   <= '0;
         opnd_q <= '0;
         idx_q  <= '0;
         wd_q   <= '0;
      end else if (wrap) begin
         if (cont) begin
            step_q <= step_q + 2'd1;
         end else if (req_start) begin
            act_q  <= 1'b1;
            kind_q <= req_kind_e'(req_kind);
            step_q <= '0;
            wr_q   <= req_write;
            op_q   <= req_addr;
            opnd_q <= req_opnd;
            idx_q  <= req_index;
            wd_q   <= req_wdata;
         end else begin
            act_q  <= 1'b0;
         end
      end
   end

   // Read capture at E fall, done one clock later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fin_q   <= 1'b0;
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         fin_q  <= wrap && act_q;
         done_q <= fin_q;
         if (wrap && act_q && cyc_rw_n)
            rdata_q <= bus_ad_in;
      end
   end

   logic low_half;
   assign low_half    = (ph < PW'(HALF));
   assign bus_as      = act_q && (ph == '0);
   assign bus_rw_n    = act_q ? cyc_rw_n : 1'b1;
   assign bus_addr_hi = act_q ? cyc_addr[AW-1:DW] : '0;
   assign bus_ad_oe   = act_q && (low_half || !cyc_rw_n);
   assign bus_ad_out  = !act_q ? '0 : (low_half ? cyc_addr[DW-1:0] : wd_q);
   assign rsp_done    = done_q;
   assign rsp_rdata   = rdata_q;

   p_as_in_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_as |-> (!bus_e && bus_ad_oe));
   p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != '0) |-> ($stable(bus_rw_n) && $stable(bus_addr_hi)));
   p_write_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_e && !bus_rw_n) |-> bus_ad_oe);
   p_read_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_e && bus_rw_n) |-> !bus_ad_oe);
   p_done_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (!bus_e && $past(bus_e, 2) && !$past(rsp_done)));
   p_ready_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> $fell(bus_e));
endmodule

// File: tb/eclk_bus_master_tb_top.sv
module eclk_bus_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0, req_opnd = '0, req_index = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, bus_e, bus_as, bus_rw_n, bus_ad_oe, rsp_done;
   logic [7:0]  bus_addr_hi, bus_ad_out, bus_ad_in, rsp_rdata;

   always #4 clk = ~clk;

   eclk_bus_master dut_i (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_kind(req_kind),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_opnd(req_opnd), .req_index(req_index), .req_ready(req_ready),
      .bus_e(bus_e), .bus_as(bus_as), .bus_rw_n(bus_rw_n),
      .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
      .bus_ad_in(bus_ad_in), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
   );

   int checks = 0, fails = 0;
   logic [15:0] exp_addr [0:1023];
   logic        exp_rw   [0:1023];
   logic [7:0]  exp_wd   [0:1023];
   int exp_n = 0, mon_n = 0, done_n = 0, cur = -1;
   logic [7:0] lat_lo = '0;
   bit in_cyc = 0, as_prev = 0, prev_e = 0, mon_on = 0;
   int since = 99, hi_cnt = 0;

   function automatic logic [7:0] mem_f(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   assign bus_ad_in = (bus_e && bus_rw_n) ? mem_f({bus_addr_hi, lat_lo}) : 8'h00;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, expv, $time);
      end
   endtask

   task automatic push(input logic [15:0] a, input logic rw, input logic [7:0] wd);
      exp_addr[exp_n] = a; exp_rw[exp_n] = rw; exp_wd[exp_n] = wd; exp_n++;
   endtask

   task automatic issue(input logic [1:0] k, input logic w, input logic [15:0] a,
                        input logic [7:0] d, input logic [15:0] o, input logic [15:0] x);
      if (k == 2'b01) begin
         push(a, 1, 0); push(a + 16'd1, 1, 0); push(a + 16'd2, 1, 0); push(o, 0, d);
      end else if (k == 2'b10) begin
         push(a, 1, 0); push(a + 16'd1, 1, 0); push(16'hFFFF, 1, 0);
         push(x + {8'h00, o[7:0]}, 0, d);
      end else begin
         push(a, !w, d);
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_start = 1; req_kind = k; req_write = w; req_addr = a;
      req_wdata = d; req_opnd = o; req_index = x;
      @(posedge clk); #1 req_start = 0;
   endtask

   // Bus monitor, sampling at the falling clock edge
   always @(negedge clk) begin
      if (mon_on) begin
         if (prev_e && !bus_e) begin
            since = 0;
            chk(hi_cnt == 2, "R1 E high width", hi_cnt, 2);
            hi_cnt = 0; in_cyc = 0;
         end else since++;
         if (bus_e) hi_cnt++;
         prev_e = bus_e;
         if (bus_as) begin
            chk(!bus_e, "R2 AS in low half", bus_e, 0);
            cur = mon_n; mon_n++; in_cyc = 1; lat_lo = bus_ad_out;
            if (cur >= exp_n) chk(0, "R7 unexpected cycle", {bus_addr_hi, bus_ad_out}, 0);
            else begin
               chk({bus_addr_hi, bus_ad_out} == exp_addr[cur] && bus_ad_oe,
                   "R8/R9/R10 cycle address", {bus_addr_hi, bus_ad_out}, exp_addr[cur]);
            end
            as_prev = 1;
         end else if (as_prev) begin
            chk(bus_ad_out == lat_lo && bus_ad_oe && !bus_e, "R2 low address held",
                bus_ad_out, lat_lo);
            as_prev = 0;
         end
         if (in_cyc && cur < exp_n) begin
            chk(bus_rw_n == exp_rw[cur] && bus_addr_hi == exp_addr[cur][15:8],
                "R3 rw/high address steady", {bus_rw_n, bus_addr_hi},
                {exp_rw[cur], exp_addr[cur][15:8]});
            if (bus_e && !exp_rw[cur])
               chk(bus_ad_oe && bus_ad_out == exp_wd[cur], "R4 write data",
                   bus_ad_out, exp_wd[cur]);
            if (bus_e && exp_rw[cur])
               chk(!bus_ad_oe, "R5 lane floats on read", bus_ad_oe, 0);
         end else if (!in_cyc) begin
            chk(bus_rw_n && !bus_ad_oe && !bus_as && bus_addr_hi == 0, "R3 idle bus",
                {bus_rw_n, bus_ad_oe, bus_as, bus_addr_hi}, 11'h400);
         end
         if (rsp_done) begin
            chk(since == 1, "R6 done one clock after E fall", since, 1);
            if (done_n < exp_n && exp_rw[done_n])
               chk(rsp_rdata == mem_f(exp_addr[done_n]), "R5 read data",
                   rsp_rdata, mem_f(exp_addr[done_n]));
            done_n++;
         end
      end
   end

   initial begin : watchdog
      #1600000;
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!bus_as && !bus_ad_oe && bus_rw_n && !rsp_done && !req_ready,
          "R3 reset state", {bus_as, bus_ad_oe, bus_rw_n, rsp_done}, 4'b0010);
      @(negedge clk); rst_n = 1; mon_on = 1;
      repeat (8) @(negedge clk);
      // R8: sweep single reads and writes, back to back
      for (int i = 0; i < 96; i++) begin
         issue(2'b00, i[0], 16'(i * 16'h0293 + 16'h0101), 8'(i * 7 + 3), 0, 0);
      end
      repeat (10) @(negedge clk);
      // R9: extended store patterns
      for (int i = 0; i < 12; i++)
         issue(2'b01, 0, 16'(16'hE000 + i * 16'h0111), 8'(16'h30 + i),
               16'(16'h5000 + i * 16'h0801), 0);
      // R10: indexed store patterns including carry and wrap
      for (int i = 0; i < 12; i++)
         issue(2'b10, 0, 16'(16'hC100 + i * 3), 8'(16'h90 + i),
               16'(16'h00F0 + i * 16'h0011), 16'(16'hFF20 + i * 16'h1234));
      // R7: start held high through a pattern is ignored until it ends
      issue(2'b01, 0, 16'hABFE, 8'h77, 16'h1234, 0);
      req_kind = 2'b00; req_write = 1; req_addr = 16'hBEEF; req_wdata = 8'h11;
      req_start = 1;
      for (int i = 0; i < 13; i++) begin
         @(negedge clk);
         chk(!req_ready, "R7 no acceptance mid pattern", req_ready, 0);
      end
      req_start = 0;
      // R7: request taken in the clock a pattern ends
      issue(2'b00, 0, 16'h4321, 0, 0, 0);
      issue(2'b11, 1, 16'h0F0F, 8'hC3, 0, 0);
      repeat (40) @(negedge clk);
      chk(mon_n == exp_n, "R7 cycle count", mon_n, exp_n);
      chk(done_n == exp_n, "R6 done count", done_n, exp_n);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule